// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit runs one single-bit operation on one operand: test, set, clear or invert a selected bit. The operand is either a 32-bit register value or an 8-bit memory byte, chosen by `byte_mode_i`. The bit number arrives on one input, whether it came from an immediate field or from a register. The unit returns three things: the destination value after the operation, a write-enable that marks results needing a write-back, and the condition flags with the zero flag updated. Address generation, bus cycles and instruction decode stay with the surrounding core.

A valid/ready pair on the input and another on the output move one operation per cycle. An accepted operation appears on the registered output on the next clock edge. That output holds steady while the consumer stalls it.

Top module: `bit_modify_unit`

## Requirements
- R1: Operation code 2'b00 (test) returns the destination unchanged with `wr_en_o` low.
- R2: Operation code 2'b11 (set) returns the destination with the selected bit forced to 1 and `wr_en_o` high.
- R3: Operation code 2'b10 (clear) returns the destination with the selected bit forced to 0 and `wr_en_o` high.
- R4: Operation code 2'b01 (change) returns the destination with the selected bit inverted and `wr_en_o` high.
- R5: For every operation, the zero flag (bit 2 of the flag vector) is the complement of the selected bit as it was before modification.
- R6: With `byte_mode_i` low, only bits [4:0] of the bit number are used (modulo 32).
- R7: With `byte_mode_i` high, only bits [2:0] of the bit number are used (modulo 8). Bits [31:8] of the result are zero, and operand bits [31:8] do not affect the result.
- R8: Flag bits other than bit 2 pass from `flags_i` to `flags_o` unchanged.
- R9: An operation is taken when `in_valid_i` and `in_ready_o` are both high, and its result is valid on the next cycle. While `out_valid_o` is high and `out_ready_i` is low, the output and its fields stay stable and `in_ready_o` is low.
- R10: In reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation |
| op_i | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| byte_mode_i | input | 1 | 1: 8-bit memory operand, 0: 32-bit register operand |
| bit_num_i | input | 32 | Bit number, immediate or register sourced |
| operand_i | input | 32 | Destination value |
| flags_i | input | 5 | Incoming condition flags, zero flag at bit 2 |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes result |
| result_o | output | 32 | Destination after operation |
| wr_en_o | output | 1 | Result must be written back |
| flags_o | output | 5 | Flags with zero flag updated |

## Verification
The bench aims at bit numbers above the operand width in both modes. A unit that skipped the wrap, or wrapped byte operands at 32, would touch a bit outside the byte or touch none at all. Byte operands carry non-zero upper bits, so a design that leaked them would show them in the result or take the zero flag from the wrong place. Set on a bit already set and clear on a bit already clear show whether Z comes from the value before or after the change. Random back-pressure on the output makes a design that overwrote a stalled result lose or duplicate entries in the scoreboard.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    BOP_TEST = 2'b00,
    BOP_CHG  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_SET  = 2'b11
  } bop_e;

  localparam int unsigned FLAG_W = 5;
  localparam int unsigned Z_POS  = 2;
endpackage

// File: rtl/bmu_bit_index.sv
module bmu_bit_index #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_W  = 32
) (
  input  logic [NUM_W-1:0]  bit_num_i,
  input  logic              byte_mode_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int unsigned REG_IDX_W  = $clog2(DATA_W);
  localparam int unsigned BYTE_IDX_W = $clog2(BYTE_W);

  logic [REG_IDX_W-1:0] idx;

  // wrap to operand width
  always_comb begin
    if (byte_mode_i) idx = REG_IDX_W'(bit_num_i[BYTE_IDX_W-1:0]);
    else             idx = bit_num_i[REG_IDX_W-1:0];
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign mask_o[g] = (idx == REG_IDX_W'(g));
  end
endmodule

// File: rtl/bmu_bit_alu.sv
module bmu_bit_alu
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  bop_e              op_i,
  input  logic              byte_mode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam logic [DATA_W-1:0] BYTE_KEEP = DATA_W'({BYTE_W{1'b1}});

  logic [DATA_W-1:0] base;
  logic              old_bit;

  assign base    = byte_mode_i ? (operand_i & BYTE_KEEP) : operand_i;
  assign old_bit = |(base & mask_i);

  always_comb begin
    result_o = base;
    wr_en_o  = 1'b1;
    unique case (op_i)
      BOP_TEST: wr_en_o  = 1'b0;
      BOP_CHG:  result_o = base ^ mask_i;
      BOP_CLR:  result_o = base & ~mask_i;
      BOP_SET:  result_o = base | mask_i;
      default:  wr_en_o  = 1'b0;
    endcase
  end

  always_comb begin
    flags_o        = flags_i;
    flags_o[Z_POS] = ~old_bit;
  end
endmodule

// File: rtl/bmu_out_reg.sv
module bmu_out_reg
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] result_i,
  input  logic              wr_en_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic accept;

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else if (accept) begin
      result_o <= result_i;
      wr_en_o  <= wr_en_i;
      flags_o  <= flags_i;
    end
  end

  // R9
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(result_o)
                                       && $stable(wr_en_o) && $stable(flags_o)));

  // R9
  stall_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bmu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        op_i,
  input  logic              byte_mode_i,
  input  logic [NUM_W-1:0]  bit_num_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [4:0]        flags_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [4:0]        flags_o
);
  localparam int unsigned REG_IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] alu_result;
  logic              alu_wr_en;
  logic [FLAG_W-1:0] alu_flags;
  bop_e              op;

  assign op = bop_e'(op_i);

  bmu_bit_index #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NUM_W(NUM_W)) u_index (
    .bit_num_i   (bit_num_i),
    .byte_mode_i (byte_mode_i),
    .mask_o      (mask)
  );

  bmu_bit_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
    .op_i        (op),
    .byte_mode_i (byte_mode_i),
    .operand_i   (operand_i),
    .mask_i      (mask),
    .flags_i     (flags_i),
    .result_o    (alu_result),
    .wr_en_o     (alu_wr_en),
    .flags_o     (alu_flags)
  );

  bmu_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .result_i    (alu_result),
    .wr_en_i     (alu_wr_en),
    .flags_i     (alu_flags),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .result_o    (result_o),
    .wr_en_o     (wr_en_o),
    .flags_o     (flags_o)
  );

  logic accept;
  assign accept = in_valid_i & in_ready_o;

  // R1
  test_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == 2'b00) |=> (!wr_en_o));

  // R1
  test_unchanged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == 2'b00 && !byte_mode_i) |=> (result_o == $past(operand_i)));

  // R5
  reg_z_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !byte_mode_i) |=>
      (flags_o[Z_POS] == !$past(operand_i[bit_num_i[REG_IDX_W-1:0]])));

  // R7
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && byte_mode_i) |=> (result_o[DATA_W-1:BYTE_W] == '0));

  // R8
  flags_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ((flags_o & ~(5'b1 << Z_POS)) == $past(flags_i & ~(5'b1 << Z_POS))));

  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && in_ready_o));
endmodule

// File: tb/tb_bit_modify_unit.sv
module tb_bit_modify_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = '0;
  logic        byte_mode = 1'b0;
  logic [31:0] bit_num = '0;
  logic [31:0] operand = '0;
  logic [4:0]  flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] result;
  logic        wr_en;
  logic [4:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit bp_on = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [4:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  bit_modify_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .byte_mode_i(byte_mode), .bit_num_i(bit_num),
    .operand_i(operand), .flags_i(flags),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .result_o(result), .wr_en_o(wr_en), .flags_o(flags_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] o, input logic bm, input logic [31:0] bn,
                                 input logic [31:0] d, input logic [4:0] f, input string tag);
    exp_t e;
    logic [31:0] b;
    int idx;
    b   = bm ? {24'h0, d[7:0]} : d;
    idx = bm ? int'(bn[2:0]) : int'(bn[4:0]);
    e.res = b;
    case (o)
      2'b01: e.res[idx] = ~b[idx];
      2'b10: e.res[idx] = 1'b0;
      2'b11: e.res[idx] = 1'b1;
      default: ;
    endcase
    e.we = (o != 2'b00);
    e.fl = f;
    e.fl[2] = ~b[idx];
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [1:0] o, input logic bm, input logic [31:0] bn,
                       input logic [31:0] d, input logic [4:0] f, input string tag);
    bit taken = 1'b0;
    op = o; byte_mode = bm; bit_num = bn; operand = d; flags = f;
    in_valid = 1'b1;
    while (!taken) begin
      @(negedge clk);
      if (in_ready) begin
        q.push_back(model(o, bm, bn, d, f, tag));
        taken = 1'b1;
      end
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  logic        held_v = 1'b0;
  logic [31:0] held_res;
  logic        held_we;
  logic [4:0]  held_fl;

  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) begin
        // R9 stalled output must not move
        check(out_valid && result == held_res && wr_en == held_we && flags_out == held_fl,
              "R9 stall hold", result, held_res);
      end
      held_v = 1'b0;
      if (out_valid && !out_ready) begin
        check(!in_ready, "R9 ready low on stall", 32'(in_ready), 32'h0);
        held_v = 1'b1; held_res = result; held_we = wr_en; held_fl = flags_out;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected result", result, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(result == e.res, e.tag, result, e.res);
          check(wr_en == e.we, {e.tag, " wr_en"}, 32'(wr_en), 32'(e.we));
          check(flags_out == e.fl, {e.tag, " R5 R8 flags"}, 32'(flags_out), 32'(e.fl));
        end
      end
    end
  end

  // random back-pressure
  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check(!out_valid, "R10 out_valid in reset", 32'(out_valid), 32'h0);
    check(in_ready, "R10 in_ready in reset", 32'(in_ready), 32'h1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    drive(2'b00, 1'b0, 32'd5,  32'h0000_0020, 5'b10101, "R1 test reg bit set");
    drive(2'b00, 1'b0, 32'd4,  32'h0000_0020, 5'b01010, "R1 test reg bit clear");
    drive(2'b11, 1'b0, 32'd31, 32'h0000_0000, 5'b00000, "R2 set msb");
    drive(2'b11, 1'b0, 32'd3,  32'h0000_0008, 5'b11111, "R2 R5 set already set");
    drive(2'b10, 1'b0, 32'd0,  32'hFFFF_FFFF, 5'b11011, "R3 clear lsb");
    drive(2'b10, 1'b0, 32'd9,  32'h0000_0000, 5'b00100, "R3 R5 clear already clear");
    drive(2'b01, 1'b0, 32'd16, 32'h0001_0000, 5'b10001, "R4 change one to zero");
    drive(2'b01, 1'b0, 32'd17, 32'h0001_0000, 5'b01110, "R4 change zero to one");
    drive(2'b11, 1'b0, 32'd37, 32'h0000_0000, 5'b00000, "R6 wrap 37 to 5");
    drive(2'b01, 1'b0, 32'hFFFF_FFE0, 32'h1234_5678, 5'b00000, "R6 wrap high bits to 0");
    drive(2'b11, 1'b1, 32'd11, 32'hABCD_EF00, 5'b00000, "R7 byte wrap 11 to 3");
    drive(2'b00, 1'b1, 32'd7,  32'hFFFF_FF7F, 5'b11111, "R7 byte test upper ignored");
    drive(2'b10, 1'b1, 32'd15, 32'h5555_55FF, 5'b10010, "R7 byte clear wrap 15");
    drive(2'b01, 1'b1, 32'd31, 32'hFFFF_FF00, 5'b01001, "R7 byte change wrap 31");
    drive(2'b00, 1'b1, 32'd8,  32'hFFFF_FF00, 5'b00000, "R7 R5 byte bit 8 wraps to 0");

    // back-to-back with back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  o  = 2'($urandom_range(0, 3));
      logic        bm = 1'($urandom_range(0, 1));
      logic [31:0] bn = $urandom;
      logic [31:0] d  = $urandom;
      logic [4:0]  f  = 5'($urandom);
      op = o; byte_mode = bm; bit_num = bn; operand = d; flags = f;
      drive(o, bm, bn, d, f, "R9 pipelined mixed");
    end
    bp_on = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    check(q.size() == 0, "R9 all results delivered", 32'(q.size()), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule